// File: doc/BRIEF.md
# Single-Issue Register Rename Stage

This block gives 32 architectural integer registers a larger pool of physical registers, so that false write-after-write and write-after-read conflicts disappear before execution. Each accepted instruction presents two source indices and a destination index. In the same cycle the block returns the physical tags the sources currently map to. If the instruction writes a destination, it also returns a newly allocated physical register and the physical register that held the old value of that destination.

A mapping table keeps the current architectural-to-physical assignment. A circular queue with an occupancy count keeps the physical registers that are not in use. A destination comes from the head of the queue and is written into the table, so the next instruction already sees it. The old tag goes downstream. It comes back through the commit port only when its instruction retires, and it then enters the tail of the queue. A commit and an allocation may occur in the same cycle. When the queue is empty, the stage refuses new instructions.

Top module: `reg_rename`

## Requirements
- R1: After reset, architectural register i maps to physical register i for every i in 0..31, and `in_ready` is high.
- R2: `out_ps1` and `out_ps2` are the current mappings of `in_rs1` and `in_rs2`, read combinationally in the same cycle. Index 0 always yields tag 0.
- R3: An accepted instruction with `in_rd_we`=1 and `in_rd`≠0 raises `out_alloc`. It receives on `out_pd` the register at the head of the free queue. The queue starts holding 32, 33, ..., NUM_PHYS-1 in that order and hands registers out first-in first-out.
- R4: From the cycle after an allocation, reads of that destination index return the newly allocated tag.
- R5: `out_stale` equals the mapping that the destination index had just before the allocation.
- R6: If the destination is index 0, or `in_rd_we`=0, or the instruction is not accepted, then `out_alloc`=0 and `out_pd`=`out_stale`=0. The mapping table and the queue stay unchanged.
- R7: When the free queue is empty, `in_ready` is low and no allocation occurs.
- R8: A cycle with `cmt_valid`=1 and a non-zero `cmt_stale` appends that tag at the tail of the free queue. A commit of tag 0 is ignored.
- R9: A commit and an allocation in the same cycle leave the queue occupancy unchanged. The occupancy never exceeds NUM_PHYS-32.
- R10: An allocated tag is never 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented |
| in_ready | output | 1 | Stage can accept (free queue not empty, not in reset) |
| in_rs1 | input | 5 | First source architectural index |
| in_rs2 | input | 5 | Second source architectural index |
| in_rd | input | 5 | Destination architectural index |
| in_rd_we | input | 1 | Instruction writes its destination |
| cmt_valid | input | 1 | A retiring instruction returns a stale tag |
| cmt_stale | input | $clog2(NUM_PHYS) | Physical tag to give back to the free queue |
| out_alloc | output | 1 | A destination was allocated this cycle |
| out_ps1 | output | $clog2(NUM_PHYS) | Physical tag of first source |
| out_ps2 | output | $clog2(NUM_PHYS) | Physical tag of second source |
| out_pd | output | $clog2(NUM_PHYS) | Newly allocated physical destination |
| out_stale | output | $clog2(NUM_PHYS) | Previous physical mapping of the destination |

## Verification
A corrupted mapping entry shows up on the very next source read of that index, or on the stale tag of the next write to it. The bench compares every output of every cycle against its own model, so such an error is reported within one instruction that touches the register. A wrong head or tail pointer, or a wrong count, shows up either on the next allocated tag, because FIFO order is checked exactly, or as `in_ready` falling one allocation too early or too late. The exhaustion scenario exposes the count error within a full pass through the queue.

// File: rtl/rename_pkg.sv
package rename_pkg;

    localparam int ARCH_REGS = 32;
    localparam int ARCH_W    = 5;

    typedef logic [ARCH_W-1:0] arch_idx_t;

    typedef struct packed {
        arch_idx_t src_a;
        arch_idx_t src_b;
        arch_idx_t dst;
        logic      dst_we;
    } rn_req_t;

    function automatic logic is_zero_reg(input arch_idx_t idx);
        return idx == '0;
    endfunction

endpackage

// File: rtl/rn_map_table.sv
module rn_map_table
    import rename_pkg::*;
#(
    parameter int PW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  arch_idx_t     rd_a,
    input  arch_idx_t     rd_b,
    input  arch_idx_t     rd_d,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_tag,
    output logic [PW-1:0] tag_a,
    output logic [PW-1:0] tag_b,
    output logic [PW-1:0] tag_d
);

    logic [PW-1:0] map_q [ARCH_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ARCH_REGS; i++) begin
                map_q[i] <= PW'(i);
            end
        end else if (wr_en && !is_zero_reg(rd_d)) begin
            map_q[rd_d] <= wr_tag;
        end
    end

    assign tag_a = is_zero_reg(rd_a) ? '0 : map_q[rd_a];
    assign tag_b = is_zero_reg(rd_b) ? '0 : map_q[rd_b];
    assign tag_d = is_zero_reg(rd_d) ? '0 : map_q[rd_d];

endmodule

// File: rtl/rn_free_list.sv
module rn_free_list
    import rename_pkg::*;
#(
    parameter int NUM_PHYS = 64,
    localparam int PW      = $clog2(NUM_PHYS),
    localparam int DEPTH   = NUM_PHYS - ARCH_REGS,
    localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pop,
    input  logic          push,
    input  logic [PW-1:0] push_tag,
    output logic [PW-1:0] head_tag,
    output logic [CW-1:0] count
);

    logic [PW-1:0]    slot_q [DEPTH];
    logic [PTR_W-1:0] head_q, tail_q;
    logic [CW-1:0]    cnt_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                slot_q[i] <= PW'(ARCH_REGS + i);
            end
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= CW'(DEPTH);
        end else begin
            if (push) begin
                slot_q[tail_q] <= push_tag;
                tail_q         <= bump(tail_q);
            end
            if (pop) begin
                head_q <= bump(head_q);
            end
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head_tag = slot_q[head_q];
    assign count    = cnt_q;

endmodule

// File: rtl/reg_rename.sv
module reg_rename
    import rename_pkg::*;
#(
    parameter int NUM_PHYS = 64,
    localparam int PW      = $clog2(NUM_PHYS),
    localparam int DEPTH   = NUM_PHYS - ARCH_REGS,
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [4:0]    in_rs1,
    input  logic [4:0]    in_rs2,
    input  logic [4:0]    in_rd,
    input  logic          in_rd_we,
    input  logic          cmt_valid,
    input  logic [PW-1:0] cmt_stale,
    output logic          out_alloc,
    output logic [PW-1:0] out_ps1,
    output logic [PW-1:0] out_ps2,
    output logic [PW-1:0] out_pd,
    output logic [PW-1:0] out_stale
);

    rn_req_t       req;
    logic          fire, alloc, give_back;
    logic [PW-1:0] head_tag, old_tag;
    logic [CW-1:0] fl_count;

    assign req       = '{src_a: in_rs1, src_b: in_rs2, dst: in_rd, dst_we: in_rd_we};
    assign in_ready  = !rst && (fl_count != '0);
    assign fire      = in_valid && in_ready;
    assign alloc     = fire && req.dst_we && !is_zero_reg(req.dst);
    assign give_back = cmt_valid && (cmt_stale != '0);

    rn_map_table #(.PW(PW)) u_map (
        .clk    (clk),
        .rst    (rst),
        .rd_a   (req.src_a),
        .rd_b   (req.src_b),
        .rd_d   (req.dst),
        .wr_en  (alloc),
        .wr_tag (head_tag),
        .tag_a  (out_ps1),
        .tag_b  (out_ps2),
        .tag_d  (old_tag)
    );

    rn_free_list #(.NUM_PHYS(NUM_PHYS)) u_free (
        .clk      (clk),
        .rst      (rst),
        .pop      (alloc),
        .push     (give_back),
        .push_tag (cmt_stale),
        .head_tag (head_tag),
        .count    (fl_count)
    );

    assign out_alloc = alloc;
    assign out_pd    = alloc ? head_tag : '0;
    assign out_stale = alloc ? old_tag  : '0;

endmodule

// File: rtl/reg_rename_chk.sv
module reg_rename_chk #(
    parameter int NUM_PHYS = 64,
    localparam int PW      = $clog2(NUM_PHYS),
    localparam int DEPTH   = NUM_PHYS - 32,
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          in_ready,
    input logic [4:0]    in_rs1,
    input logic [4:0]    in_rd,
    input logic          in_rd_we,
    input logic          cmt_valid,
    input logic [PW-1:0] cmt_stale,
    input logic          out_alloc,
    input logic [PW-1:0] out_ps1,
    input logic [PW-1:0] out_pd,
    input logic [PW-1:0] out_stale,
    input logic [CW-1:0] fl_count
);

    // R6
    idle_dest_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !out_alloc |-> (out_pd == '0 && out_stale == '0));

    // R7
    alloc_needs_accept_chk: assert property (@(posedge clk) disable iff (rst)
        out_alloc |-> (in_valid && in_ready && in_rd_we && in_rd != '0));

    // R10
    pd_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        out_alloc |-> out_pd != '0);

    // R4
    new_map_seen_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(out_alloc) && in_rs1 == $past(in_rd)) |-> out_ps1 == $past(out_pd));

    // R5
    stale_is_prev_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(out_alloc) && out_alloc && in_rd == $past(in_rd)) |-> out_stale == $past(out_pd));

    // R9
    balanced_count_chk: assert property (@(posedge clk) disable iff (rst)
        (out_alloc && cmt_valid && cmt_stale != '0) |=> $stable(fl_count));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        int'(fl_count) <= DEPTH);

endmodule

bind reg_rename reg_rename_chk #(.NUM_PHYS(NUM_PHYS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_rs1    (in_rs1),
    .in_rd     (in_rd),
    .in_rd_we  (in_rd_we),
    .cmt_valid (cmt_valid),
    .cmt_stale (cmt_stale),
    .out_alloc (out_alloc),
    .out_ps1   (out_ps1),
    .out_pd    (out_pd),
    .out_stale (out_stale),
    .fl_count  (fl_count)
);

// File: tb/reg_rename_tb.sv
module reg_rename_tb;

    localparam int NUM_PHYS = 64;
    localparam int PW       = $clog2(NUM_PHYS);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0, in_rd_we = 1'b0, cmt_valid = 1'b0;
    logic [4:0]    in_rs1 = '0, in_rs2 = '0, in_rd = '0;
    logic [PW-1:0] cmt_stale = '0;
    logic          in_ready, out_alloc;
    logic [PW-1:0] out_ps1, out_ps2, out_pd, out_stale;

    int checks = 0;
    int errors = 0;
    int exp_map [32];
    int exp_free [$];
    int pending [$];
    bit finished = 1'b0;

    always #4 clk = ~clk;

    reg_rename #(.NUM_PHYS(NUM_PHYS)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_rs1(in_rs1), .in_rs2(in_rs2), .in_rd(in_rd), .in_rd_we(in_rd_we),
        .cmt_valid(cmt_valid), .cmt_stale(cmt_stale), .out_alloc(out_alloc),
        .out_ps1(out_ps1), .out_ps2(out_ps2), .out_pd(out_pd), .out_stale(out_stale)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input logic v, input int a, input int b, input int d, input logic we,
                        input logic cv, input int ct, input string req);
        bit rdy, fire, alc;
        int pd, st;
        @(negedge clk);
        in_valid = v; in_rs1 = 5'(a); in_rs2 = 5'(b); in_rd = 5'(d); in_rd_we = we;
        cmt_valid = cv; cmt_stale = PW'(ct);
        #1;
        rdy  = exp_free.size() != 0;
        fire = v && rdy;
        alc  = fire && we && d != 0;
        pd   = alc ? exp_free[0] : 0;
        st   = alc ? exp_map[d] : 0;
        chk(req, "in_ready", int'(in_ready), int'(rdy));
        chk(req, "out_alloc", int'(out_alloc), int'(alc));
        chk(req, "out_ps1", int'(out_ps1), exp_map[a]);
        chk(req, "out_ps2", int'(out_ps2), exp_map[b]);
        chk(req, "out_pd", int'(out_pd), pd);
        chk(req, "out_stale", int'(out_stale), st);
        @(posedge clk);
        if (alc) begin
            void'(exp_free.pop_front());
            exp_map[d] = pd;
            pending.push_back(st);
        end
        if (cv && ct != 0) exp_free.push_back(ct);
        #1;
        in_valid = 1'b0; cmt_valid = 1'b0;
    endtask

    task automatic t_reset();
        for (int i = 0; i < 32; i++) exp_map[i] = i;
        exp_free.delete();
        for (int i = 32; i < NUM_PHYS; i++) exp_free.push_back(i);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: identity map visible on idle reads
        for (int i = 0; i < 32; i += 4) step(1'b0, i, 31 - i, 0, 1'b0, 1'b0, 0, "R1");
    endtask

    task automatic t_basic();
        // R3 R5: first destination gets 32, old mapping 3 comes out
        step(1'b1, 1, 2, 3, 1'b1, 1'b0, 0, "R3");
        // R4 R5: source sees 32, rewrite gives 33 with stale 32
        step(1'b1, 3, 3, 3, 1'b1, 1'b0, 0, "R4");
        step(1'b1, 3, 0, 7, 1'b1, 1'b0, 0, "R5");
        // R2: zero source reads 0
        step(1'b1, 0, 7, 9, 1'b0, 1'b0, 0, "R2");
    endtask

    task automatic t_no_dest();
        // R6: x0 destination, no-write, and idle cycles allocate nothing
        step(1'b1, 4, 5, 0, 1'b1, 1'b0, 0, "R6");
        step(1'b1, 4, 5, 6, 1'b0, 1'b0, 0, "R6");
        step(1'b0, 6, 7, 6, 1'b1, 1'b0, 0, "R6");
        step(1'b1, 6, 5, 10, 1'b1, 1'b0, 0, "R6");
    endtask

    task automatic t_overlap();
        // R9: commit and allocation in the same cycle
        step(1'b1, 1, 2, 11, 1'b1, 1'b1, pending.pop_front(), "R9");
        step(1'b1, 11, 3, 12, 1'b1, 1'b1, pending.pop_front(), "R9");
    endtask

    task automatic t_exhaust();
        int r;
        r = 13;
        // R7 R10: drain the queue with rotating destinations
        while (exp_free.size() != 0) begin
            step(1'b1, r, (r + 5) % 32, r, 1'b1, 1'b0, 0, "R10");
            r = (r % 31) + 1;
        end
        step(1'b1, 2, 3, 4, 1'b1, 1'b0, 0, "R7");
        // R8: commit of tag 0 must not refill
        step(1'b0, 2, 3, 4, 1'b1, 1'b1, 0, "R8");
        step(1'b1, 2, 3, 4, 1'b1, 1'b0, 0, "R8");
        // R8: a real commit refills and the tag is handed out next
        step(1'b0, 2, 3, 4, 1'b1, 1'b1, pending.pop_front(), "R8");
        step(1'b1, 4, 3, 4, 1'b1, 1'b1, pending.pop_front(), "R8");
        step(1'b1, 4, 3, 5, 1'b1, 1'b0, 0, "R3");
        step(1'b1, 5, 4, 6, 1'b1, 1'b0, 0, "R7");
    endtask

    task automatic t_refill_order();
        // R3: refilled tags come back in commit order
        for (int k = 0; k < 4; k++) step(1'b0, 0, 0, 0, 1'b0, 1'b1, pending.pop_front(), "R8");
        for (int k = 0; k < 4; k++) step(1'b1, 20 + k, 1, 20 + k, 1'b1, 1'b0, 0, "R3");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_no_dest();
        t_overlap();
        t_exhaust();
        t_refill_order();
        t_reset();
        step(1'b1, 8, 9, 8, 1'b1, 1'b0, 0, "R1");
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule